// File: doc/BRIEF.md
# Fractional PLL Rate Calculator

This block works out the output frequency of a fractional-N PLL from its divider settings and the frequency of the clock that feeds it. A pulse on the start input samples all operands at once. A fixed-length sequence of multiplications and iterative divisions follows. The block then presents a 64-bit integer rate in Hz, together with an error flag, in the single cycle in which `done_o` is high. Both results stay on the outputs until the next calculation completes.

Two encodings of the divider fields are supported. In the direct encoding every field holds the real divider value, and an optional 24-bit fraction adds a sub-integer part to the feedback ratio. In the minus-one encoding every stored divider is one less than the divider it stands for, no fraction is applied, and only one output divider takes part. A bypass flag makes the block report the parent rate unchanged. A divider of zero in the direct encoding yields a zero rate with the error flag set.

Top module: `pll_rate_calc`

## Requirements
- R1: With `minus_one_i`=0, `bypass_i`=0 and `int_mode_i`=1, the result is floor(floor(floor(P*FB/REF)/OD1)/OD2). Here P is `parent_rate_i`, FB is `fb_div_i[11:0]`, REF is `ref_div_i`, OD1 is `post1_div_i[2:0]` and OD2 is `post2_div_i`. `err_o` is 0.
- R2: With `minus_one_i`=0 and `int_mode_i`=0, the term floor(P*FRAC/REF) shifted right by 24 is added to floor(P*FB/REF) before the two output divisions, where FRAC is `frac_i`. With `int_mode_i`=1 the fraction has no effect.
- R3: In the direct encoding, `fb_div_i[12]` and `post1_div_i[3]` are ignored.
- R4: With `minus_one_i`=1 and `bypass_i`=0, the result is floor(floor(P*(FB13+1)/(REF+1))/(OD4+1)), where FB13 is all 13 bits of `fb_div_i` and OD4 is all 4 bits of `post1_div_i`. `post2_div_i`, `frac_i` and `int_mode_i` are ignored, and `err_o` is 0.
- R5: With `bypass_i`=1, the result equals P, `err_o` is 0, and every other field is ignored, zero dividers included.
- R6: In the direct encoding without bypass, if REF, OD1 or OD2 is zero, the result is 0 and `err_o` is 1.
- R7: A start accepted while idle raises `busy_o` in the next cycle. `done_o` is high for exactly one cycle, exactly 4*(ACC_W+2) = 264 clock edges after the accepting edge, and `busy_o` is low in that cycle. A start in the `done_o` cycle is accepted.
- R8: While `busy_o` is high, start and operand changes are ignored. `rate_o` and `err_o` change only in a `done_o` cycle.
- R9: After synchronous reset, `busy_o`, `done_o`, `rate_o` and `err_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled while idle |
| parent_rate_i | input | 32 | Parent clock rate in Hz |
| fb_div_i | input | 13 | Feedback divider field |
| ref_div_i | input | 6 | Reference divider field |
| post1_div_i | input | 4 | First output divider field |
| post2_div_i | input | 3 | Second output divider field (direct encoding only) |
| frac_i | input | 24 | Fractional feedback, units of 2^-24 |
| int_mode_i | input | 1 | 1 = integer only, 0 = fraction added |
| bypass_i | input | 1 | Report the parent rate unchanged |
| minus_one_i | input | 1 | 1 = fields hold divider minus one |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| rate_o | output | 64 | Calculated rate in Hz |
| err_o | output | 1 | Zero divider detected |

## Verification
Two things can happen in the same cycle: the completion of one calculation, with `done_o` high and the results updating, and the acceptance of the next start. The bench provokes this by holding `start_i` high through a whole calculation while it changes the operand fields. The early requests must be ignored. The request that is still standing in the `done_o` cycle must be taken with the fields present then. A behavioural model counts the latency and computes each result with 64-bit integer arithmetic. It is compared against `busy_o`, `done_o`, `rate_o` and `err_o` on every clock. This shows whether the first result came out intact, whether the second calculation started on exactly that edge, and whether its outputs stayed put until its own strobe.

// File: rtl/pll_rate_pkg.sv
package pll_rate_pkg;
  typedef enum logic [1:0] {
    PH_INT   = 2'd0,
    PH_FRAC  = 2'd1,
    PH_POST1 = 2'd2,
    PH_POST2 = 2'd3
  } phase_e;

  localparam int unsigned NUM_PHASES = 4;
endpackage

// File: rtl/prc_decode.sv
// Turns the raw divider fields into true divider values for either encoding
// and flags a zero divider in the direct encoding.
module prc_decode #(
  parameter int unsigned FB_W    = 13,
  parameter int unsigned REF_W   = 6,
  parameter int unsigned POST1_W = 4,
  parameter int unsigned POST2_W = 3
) (
  input  logic [FB_W-1:0]    fb_i,
  input  logic [REF_W-1:0]   ref_i,
  input  logic [POST1_W-1:0] post1_i,
  input  logic [POST2_W-1:0] post2_i,
  input  logic               int_mode_i,
  input  logic               minus_one_i,
  output logic [FB_W:0]      fb_o,
  output logic [REF_W:0]     ref_o,
  output logic [POST1_W:0]   post1_o,
  output logic [POST2_W:0]   post2_o,
  output logic               frac_en_o,
  output logic               zero_o
);
  localparam int unsigned DIR_FB_W = FB_W - 1;
  localparam int unsigned DIR_P1_W = POST1_W - 1;

  always_comb begin
    if (minus_one_i) begin
      fb_o      = (FB_W+1)'(fb_i) + (FB_W+1)'(1);
      ref_o     = (REF_W+1)'(ref_i) + (REF_W+1)'(1);
      post1_o   = (POST1_W+1)'(post1_i) + (POST1_W+1)'(1);
      post2_o   = (POST2_W+1)'(1);
      frac_en_o = 1'b0;
      zero_o    = 1'b0;
    end else begin
      fb_o      = (FB_W+1)'(fb_i[DIR_FB_W-1:0]);
      ref_o     = (REF_W+1)'(ref_i);
      post1_o   = (POST1_W+1)'(post1_i[DIR_P1_W-1:0]);
      post2_o   = (POST2_W+1)'(post2_i);
      frac_en_o = ~int_mode_i;
      zero_o    = (ref_i == '0) || (post1_i[DIR_P1_W-1:0] == '0) || (post2_i == '0);
    end
  end
endmodule

// File: rtl/prc_seq_div.sv
// Restoring divider that produces one quotient bit per cycle.
// The operands load on go_i, and fin_o pulses W cycles later.
module prc_seq_div #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quo_o,
  output logic         fin_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          fin_q;
  logic [W:0]    rem_sh, diff;

  assign rem_sh = {rem_q, quo_q[W-1]};
  assign diff   = rem_sh - {1'b0, dvs_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (go_i) begin
        rem_q <= '0;
        quo_q <= dividend_i;
        dvs_q <= divisor_i;
        cnt_q <= CW'(W);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CW'(1);
        quo_q <= {quo_q[W-2:0], ~diff[W]};
        rem_q <= diff[W] ? rem_sh[W-1:0] : diff[W-1:0];
        if (cnt_q == CW'(1)) fin_q <= 1'b1;
      end
    end
  end

  assign quo_o = quo_q;
  assign fin_o = fin_q;
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
  import pll_rate_pkg::*;
#(
  parameter int unsigned PRATE_W = 32,
  parameter int unsigned FB_W    = 13,
  parameter int unsigned REF_W   = 6,
  parameter int unsigned POST1_W = 4,
  parameter int unsigned POST2_W = 3,
  parameter int unsigned FRAC_W  = 24,
  parameter int unsigned ACC_W   = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [PRATE_W-1:0] parent_rate_i,
  input  logic [FB_W-1:0]    fb_div_i,
  input  logic [REF_W-1:0]   ref_div_i,
  input  logic [POST1_W-1:0] post1_div_i,
  input  logic [POST2_W-1:0] post2_div_i,
  input  logic [FRAC_W-1:0]  frac_i,
  input  logic               int_mode_i,
  input  logic               bypass_i,
  input  logic               minus_one_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [ACC_W-1:0]   rate_o,
  output logic               err_o
);
  logic [FB_W:0]    dec_fb;
  logic [REF_W:0]   dec_ref;
  logic [POST1_W:0] dec_p1;
  logic [POST2_W:0] dec_p2;
  logic             dec_frac_en, dec_zero;

  prc_decode #(
    .FB_W(FB_W), .REF_W(REF_W), .POST1_W(POST1_W), .POST2_W(POST2_W)
  ) u_decode (
    .fb_i(fb_div_i), .ref_i(ref_div_i), .post1_i(post1_div_i), .post2_i(post2_div_i),
    .int_mode_i(int_mode_i), .minus_one_i(minus_one_i),
    .fb_o(dec_fb), .ref_o(dec_ref), .post1_o(dec_p1), .post2_o(dec_p2),
    .frac_en_o(dec_frac_en), .zero_o(dec_zero)
  );

  logic [ACC_W-1:0]   prod_int, prod_frac;
  assign prod_int  = ACC_W'(parent_rate_i) * ACC_W'(dec_fb);
  assign prod_frac = ACC_W'(parent_rate_i) * ACC_W'(frac_i);

  logic [ACC_W-1:0]   op_int_q, op_frac_q, acc_q;
  logic [ACC_W-1:0]   ref_q, p1_q, p2_q;
  logic [PRATE_W-1:0] parent_q;
  logic               frac_en_q, zero_q, bypass_q;
  logic               busy_q, done_q, err_q, kick_q;
  logic [ACC_W-1:0]   rate_q;
  phase_e             phase_q;

  logic [ACC_W-1:0]   div_dvd, div_dvs, div_quo;
  logic               div_fin;

  always_comb begin
    case (phase_q)
      PH_INT:   begin div_dvd = op_int_q;  div_dvs = ref_q; end
      PH_FRAC:  begin div_dvd = op_frac_q; div_dvs = ref_q; end
      PH_POST1: begin div_dvd = acc_q;     div_dvs = p1_q;  end
      default:  begin div_dvd = acc_q;     div_dvs = p2_q;  end
    endcase
  end

  prc_seq_div #(.W(ACC_W)) u_div (
    .clk(clk), .rst(rst), .go_i(kick_q),
    .dividend_i(div_dvd), .divisor_i(div_dvs),
    .quo_o(div_quo), .fin_o(div_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_int_q  <= '0;
      op_frac_q <= '0;
      acc_q     <= '0;
      ref_q     <= '0;
      p1_q      <= '0;
      p2_q      <= '0;
      parent_q  <= '0;
      frac_en_q <= 1'b0;
      zero_q    <= 1'b0;
      bypass_q  <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      kick_q    <= 1'b0;
      rate_q    <= '0;
      phase_q   <= PH_INT;
    end else begin
      done_q <= 1'b0;
      kick_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          op_int_q  <= prod_int;
          op_frac_q <= prod_frac;
          ref_q     <= ACC_W'(dec_ref);
          p1_q      <= ACC_W'(dec_p1);
          p2_q      <= ACC_W'(dec_p2);
          parent_q  <= parent_rate_i;
          frac_en_q <= dec_frac_en;
          zero_q    <= dec_zero;
          bypass_q  <= bypass_i;
          busy_q    <= 1'b1;
          kick_q    <= 1'b1;
          phase_q   <= PH_INT;
        end
      end else if (div_fin) begin
        case (phase_q)
          PH_INT:   acc_q <= div_quo;
          PH_FRAC:  if (frac_en_q) acc_q <= acc_q + (div_quo >> FRAC_W);
          PH_POST1: acc_q <= div_quo;
          default:  ;
        endcase
        if (phase_q == PH_POST2) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          err_q  <= !bypass_q && zero_q;
          if (bypass_q)    rate_q <= ACC_W'(parent_q);
          else if (zero_q) rate_q <= '0;
          else             rate_q <= div_quo;
        end else begin
          phase_q <= phase_e'(phase_q + 2'd1);
          kick_q  <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rate_o = rate_q;
  assign err_o  = err_q;
endmodule

// File: rtl/prc_checker.sv
module prc_checker #(
  parameter int unsigned PRATE_W = 32,
  parameter int unsigned ACC_W   = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               start_i,
  input logic               bypass_i,
  input logic [PRATE_W-1:0] parent_rate_i,
  input logic               busy_o,
  input logic               done_o,
  input logic [ACC_W-1:0]   rate_o,
  input logic               err_o
);
  localparam int unsigned LAT = pll_rate_pkg::NUM_PHASES * (ACC_W + 2);

  logic [31:0]        win_q;
  logic [PRATE_W-1:0] par_q;
  logic               byp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
      par_q <= '0;
      byp_q <= 1'b0;
    end else if (start_i && !busy_o) begin
      win_q <= '0;
      par_q <= parent_rate_i;
      byp_q <= bypass_i;
    end else if (busy_o) begin
      win_q <= win_q + 32'd1;
    end
  end

  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (win_q == LAT));
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_idle_at_done_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  p_bypass_r5: assert property (@(posedge clk) disable iff (rst)
    (done_o && byp_q) |-> (rate_o == ACC_W'(par_q) && !err_o));
  p_err_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_o) |-> (rate_o == '0));
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(rate_o) && $stable(err_o)));
endmodule

bind pll_rate_calc prc_checker #(.PRATE_W(PRATE_W), .ACC_W(ACC_W)) u_prc_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .bypass_i(bypass_i),
  .parent_rate_i(parent_rate_i), .busy_o(busy_o), .done_o(done_o),
  .rate_o(rate_o), .err_o(err_o)
);

// File: tb/tb_pll_rate_calc.sv
`timescale 1ns/1ps
module tb_pll_rate_calc;
  localparam int LAT = 4 * (64 + 2);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] parent_rate_i = '0;
  logic [12:0] fb_div_i = '0;
  logic [5:0]  ref_div_i = '0;
  logic [3:0]  post1_div_i = '0;
  logic [2:0]  post2_div_i = '0;
  logic [23:0] frac_i = '0;
  logic        int_mode_i = 1'b1;
  logic        bypass_i = 1'b0;
  logic        minus_one_i = 1'b0;
  logic        busy_o, done_o, err_o;
  logic [63:0] rate_o;

  always #4 clk = ~clk;

  pll_rate_calc dut (
    .clk(clk), .rst(rst), .start_i(start_i), .parent_rate_i(parent_rate_i),
    .fb_div_i(fb_div_i), .ref_div_i(ref_div_i), .post1_div_i(post1_div_i),
    .post2_div_i(post2_div_i), .frac_i(frac_i), .int_mode_i(int_mode_i),
    .bypass_i(bypass_i), .minus_one_i(minus_one_i), .busy_o(busy_o),
    .done_o(done_o), .rate_o(rate_o), .err_o(err_o)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_tag = "R9";

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [64:0] ref_calc(longint unsigned p, longint unsigned fb,
      longint unsigned rf, longint unsigned o1, longint unsigned o2,
      longint unsigned fr, bit intm, bit byp, bit alt);
    longint unsigned a;
    if (byp) return {1'b0, p};
    if (alt) begin
      a = p * (fb + 1);
      a = a / (rf + 1);
      a = a / (o1 + 1);
      return {1'b0, a};
    end
    fb = fb & 64'hFFF;
    o1 = o1 & 64'h7;
    if (rf == 0 || o1 == 0 || o2 == 0) return {1'b1, 64'd0};
    a = (p * fb) / rf;
    if (!intm) a = a + (((p * fr) / rf) >> 24);
    a = a / o1;
    a = a / o2;
    return {1'b0, a};
  endfunction

  // behavioural model
  int          m_cnt;
  bit          m_busy, m_done, m_err, m_perr;
  logic [63:0] m_rate, m_prate;
  string       m_tag = "R9";
  logic [64:0] tmp;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= 0; m_busy <= 0; m_done <= 0; m_err <= 0; m_rate <= '0;
    end else begin
      m_done <= 0;
      if (m_cnt != 0) begin
        if (m_cnt == 1) begin
          m_done <= 1; m_busy <= 0; m_rate <= m_prate; m_err <= m_perr;
        end
        m_cnt <= m_cnt - 1;
      end else if (start_i) begin
        tmp = ref_calc(parent_rate_i, fb_div_i, ref_div_i, post1_div_i, post2_div_i,
                       frac_i, int_mode_i, bypass_i, minus_one_i);
        m_perr  <= tmp[64];
        m_prate <= tmp[63:0];
        m_tag   <= cur_tag;
        m_busy  <= 1;
        m_cnt   <= LAT;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(busy_o === m_busy, "R7", "busy", busy_o, m_busy);
      chk(done_o === m_done, "R7", "done", done_o, m_done);
      chk(rate_o === m_rate, m_tag, "rate", rate_o, m_rate);
      chk(err_o === m_err, m_tag, "err", err_o, m_err);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic set_ops(input logic [31:0] p, input logic [12:0] fb, input logic [5:0] rf,
                         input logic [3:0] o1, input logic [2:0] o2, input logic [23:0] fr,
                         input bit intm, input bit byp, input bit alt);
    parent_rate_i = p; fb_div_i = fb; ref_div_i = rf; post1_div_i = o1;
    post2_div_i = o2; frac_i = fr; int_mode_i = intm; bypass_i = byp; minus_one_i = alt;
  endtask

  task automatic run_op(input string tag, input logic [31:0] p, input logic [12:0] fb,
                        input logic [5:0] rf, input logic [3:0] o1, input logic [2:0] o2,
                        input logic [23:0] fr, input bit intm, input bit byp, input bit alt);
    cur_tag = tag;
    set_ops(p, fb, rf, o1, o2, fr, intm, byp, alt);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (m_busy || busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk(busy_o === 1'b0 && done_o === 1'b0, "R9", "busy|done after reset", {busy_o, done_o}, 0);
    chk(rate_o === 64'd0 && err_o === 1'b0, "R9", "rate after reset", rate_o, 0);

    // R1: integer mode
    run_op("R1", 32'd24000000, 13'd100, 6'd1, 4'd2, 3'd1, 24'h0, 1, 0, 0);
    run_op("R1", 32'd24000000, 13'd50, 6'd3, 4'd1, 3'd2, 24'h123456, 1, 0, 0);
    run_op("R1", 32'd1000003, 13'd7, 6'd3, 4'd5, 3'd3, 24'h0, 1, 0, 0);
    // R2: fractional mode
    run_op("R2", 32'd24000000, 13'd50, 6'd1, 4'd1, 3'd1, 24'h800000, 0, 0, 0);
    run_op("R2", 32'd3, 13'd1, 6'd7, 4'd1, 3'd1, 24'hFFFFFF, 0, 0, 0);
    run_op("R2", 32'hFFFFFFFF, 13'd4095, 6'd63, 4'd7, 3'd7, 24'hFFFFFF, 0, 0, 0);
    // R3: ignored upper bits in direct encoding
    run_op("R3", 32'd24000000, 13'h1064, 6'd1, 4'b1010, 3'd1, 24'h0, 1, 0, 0);
    // R4: minus-one encoding
    run_op("R4", 32'd24000000, 13'd99, 6'd0, 4'd1, 3'd0, 24'hABCDEF, 0, 0, 1);
    run_op("R4", 32'hFFFFFFFF, 13'h1FFF, 6'd63, 4'd15, 3'd5, 24'h0, 1, 0, 1);
    // R5: bypass
    run_op("R5", 32'd32768, 13'd0, 6'd0, 4'd0, 3'd0, 24'h0, 1, 1, 0);
    run_op("R5", 32'hDEADBEEF, 13'd77, 6'd2, 4'd3, 3'd1, 24'h1, 0, 1, 1);
    // R6: zero dividers
    run_op("R6", 32'd24000000, 13'd100, 6'd0, 4'd1, 3'd1, 24'h0, 1, 0, 0);
    run_op("R6", 32'd24000000, 13'd100, 6'd1, 4'b1000, 3'd1, 24'h0, 1, 0, 0);
    run_op("R6", 32'd24000000, 13'd100, 6'd1, 4'd1, 3'd0, 24'h0, 0, 0, 0);

    // R8: new start and operands during busy are ignored
    cur_tag = "R8";
    set_ops(32'd12000000, 13'd10, 6'd1, 4'd1, 3'd1, 24'h0, 1, 0, 0);
    start_i = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 20; k++) begin
      set_ops(32'd5 + k, 13'd3, 6'd0, 4'd0, 3'd0, 24'h0, 1, 0, 0);
      @(negedge clk);
    end
    start_i = 1'b0;
    while (m_busy || busy_o) @(negedge clk);
    @(negedge clk);

    // R7: start held through completion, second op taken in done cycle
    cur_tag = "R7";
    set_ops(32'd19200000, 13'd125, 6'd2, 4'd3, 3'd1, 24'h0, 1, 0, 0);
    start_i = 1'b1;
    @(negedge clk);
    set_ops(32'd27000000, 13'd40, 6'd1, 4'd2, 3'd2, 24'h400000, 0, 0, 0);
    while (!done_o) @(negedge clk);
    @(negedge clk);
    start_i = 1'b0;
    while (m_busy || busy_o) @(negedge clk);
    @(negedge clk);

    // mixed random operations
    for (int k = 0; k < 40; k++) begin
      logic [31:0] rp;
      rp = $urandom;
      run_op((k % 2) ? "R2" : "R4", rp, 13'($urandom), 6'($urandom), 4'($urandom),
             3'($urandom), 24'($urandom), bit'($urandom), 1'b0, bit'(k % 2 == 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule